// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits between a simple word-addressed register bus and an 8-bit NAND flash bus. Software programs a mode register to raise the command-latch and address-latch lines, pick one of four flash devices and enable its chip select. It then moves bytes through a data register. Every access to the data register runs one timed strobe cycle on the flash bus. A write cycle pulses the write strobe low and drives the byte. A read cycle pulses the read strobe low and captures the byte that the device returns.

The width of the strobe pulse and the time the bus is held after it are set in bus clocks through a packed timing register. The flash ready/busy line appears in the status register, next to a flag that shows a strobe cycle is in progress. A data-register access that arrives while a cycle is still running is stalled on the bus handshake and is never dropped. A soft reset, started through the reset register, returns the mode and timing registers to their reset values and clears itself when it is done.

Bus protocol: the host holds `bus_req` together with address, direction and write data until `bus_ack` pulses high for one clock. For a read, `bus_rdata` is valid in that same cycle.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, the timing register reads 0xFF, status reads 0x00, all chip-enable outputs are high and both strobes are high.
- R2: The mode register (word offset 0x04) reads back what was written. Bit 0 drives `nand_cle` and bit 1 drives `nand_ale`, each one clock after the write takes effect.
- R3: Mode bit 4 set drives low only the chip-enable output chosen by mode bits 3:2. With bit 4 clear, all chip-enable outputs stay high.
- R4: The timing register (offset 0x14) holds the hold field in bits 7:4 and the pulse field in bits 3:0. A field written as 0 is stored and read back as 1.
- R5: A data-register write (offset 0x00) while mode bit 7, bit 1 or bit 0 is set runs a write cycle. `nand_we_n` is low for pulse+1 clocks, `nand_dout` carries write-data bits 7:0, and `nand_doe` stays high for (pulse+1)+(hold+2) clocks.
- R6: A data-register write while mode bits 7, 1 and 0 are all clear is acknowledged but runs no strobe cycle.
- R7: A data-register read runs a read cycle with `nand_re_n` low for pulse+1 clocks. It completes with the byte on `nand_din` at the strobe's rising edge, zero-extended to 32 bits.
- R8: Status (offset 0x08) bit 7 reads 1 while `nand_rb_n` is low, one clock behind the pin. Bit 6 reads 1 while a strobe cycle is running.
- R9: A data-register access issued while a strobe cycle runs is held off until that cycle ends, then performed. Successive accesses all reach the flash bus in order.
- R10: Writing 1 to reset register (offset 0x18) bit 0 makes that bit read 1 until the soft reset finishes, then 0. The mode register is then 0x00 and the timing register 0xFF.
- R11: Offsets 0x0C, 0x10 and 0x1C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word-spaced registers |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-clock access completion |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 4 | Active-low chip enables, one per device |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dout | output | 8 | Byte driven to the flash |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte returned by the flash |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest case to reach is a data-register access that arrives while an earlier strobe cycle is still running. The host only learns of a posted write through its early acknowledge, so the stall path needs accesses issued back to back. The stimulus sets short timing and issues two writes and then a read with no gap. It checks that both write bytes appear on the bus in order and that the read returns the input byte only after both cycles are done. The soft-reset window is reached by reading the reset bit straight after setting it and then polling until it clears.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  // word index of each register (byte address bits above bit 1)
  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_MODE = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_TIME = 3'd5;
  localparam logic [2:0] IDX_RST  = 3'd6;

  // mode register bit positions
  localparam int MB_CLE  = 0;
  localparam int MB_ALE  = 1;
  localparam int MB_CSLO = 2;
  localparam int MB_CE   = 4;
  localparam int MB_WEN  = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PULSE, SQ_HOLD} sq_state_t;
endpackage

// File: rtl/nfc_regs.sv
module nfc_regs #(
  parameter int TW         = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_mode,
  input  logic            wr_time,
  input  logic            wr_rst,
  input  logic [7:0]      wbyte,
  output logic [7:0]      mode_q,
  output logic [2*TW-1:0] time_q,
  output logic            rst_busy
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam logic [TW-1:0] FMAX = '1;

  logic [RCW-1:0] rcnt;
  logic           clear_now;

  function automatic logic [TW-1:0] fix_field(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign clear_now = (rcnt == RCW'(1));
  assign rst_busy  = (rcnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clear_now) begin
      mode_q <= '0;
      time_q <= {FMAX, FMAX};
    end else begin
      if (wr_mode) mode_q <= wbyte;
      if (wr_time) time_q <= {fix_field(wbyte[2*TW-1:TW]), fix_field(wbyte[TW-1:0])};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   rcnt <= '0;
    else if (rcnt != '0)       rcnt <= rcnt - RCW'(1);
    else if (wr_rst && wbyte[0]) rcnt <= RCW'(RST_CYCLES);
  end

  // R4: neither timing field can hold zero
  a_r4_fields_nonzero: assert property (@(posedge clk) disable iff (rst)
    (time_q[TW-1:0] != '0) && (time_q[2*TW-1:TW] != '0));

  // R10: when the soft reset finishes the registers are back at reset values
  a_r10_clear_done: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_busy) |-> (mode_q == 8'h00 && time_q == {FMAX, FMAX}));
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_rd,
  input  logic [7:0]    wbyte,
  input  logic [TW-1:0] spw,
  input  logic [TW-1:0] hold,
  input  logic [7:0]    din,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dout,
  output logic          doe,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rbyte
);
  localparam int CW = TW + 1;

  sq_state_t     state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] hold_q;
  logic          rd_q;

  assign busy = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      hold_q <= '0;
      rd_q   <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dout   <= '0;
      doe    <= 1'b0;
      done   <= 1'b0;
      rbyte  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_PULSE;
          cnt    <= CW'(spw);
          hold_q <= hold;
          rd_q   <= is_rd;
          we_n   <= is_rd;
          re_n   <= !is_rd;
          doe    <= !is_rd;
          if (!is_rd) dout <= wbyte;
        end
        SQ_PULSE: if (cnt == '0) begin
          state <= SQ_HOLD;
          cnt   <= CW'(hold_q) + CW'(1);
          we_n  <= 1'b1;
          re_n  <= 1'b1;
          if (rd_q) rbyte <= din;
        end else begin
          cnt <= cnt - CW'(1);
        end
        SQ_HOLD: if (cnt == '0) begin
          state <= SQ_IDLE;
          doe   <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // checker-side pulse length measurement
  logic [CW:0]   low_run;
  logic [TW-1:0] spw_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      spw_seen <= '0;
    end else begin
      low_run <= (!we_n || !re_n) ? low_run + (CW+1)'(1) : '0;
      if (start && state == SQ_IDLE) spw_seen <= spw;
    end
  end

  // R5/R7: a finished strobe pulse lasted pulse+1 clocks
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    (low_run != '0 && we_n && re_n) |-> (low_run == (CW+1)'(spw_seen) + (CW+1)'(1)));

  // R5: write and read strobes are never low together
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  // R5: data is only driven inside a strobe cycle
  a_r5_doe_in_cycle: assert property (@(posedge clk) disable iff (rst)
    doe |-> busy);

  // R9: completion is a single-clock event
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nfc_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int NUM_CS     = 4,
  parameter int TW         = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dout,
  output logic              nand_doe,
  input  logic [7:0]        nand_din,
  input  logic              nand_rb_n
);
  localparam int CS_W = $clog2(NUM_CS);

  logic [2:0]        idx;
  logic              acc, is_data, launch_ok, seq_start;
  logic              rd_wait, rb_busy;
  logic [7:0]        mode_q;
  logic [2*TW-1:0]   time_q;
  logic              rst_busy;
  logic              sq_busy, sq_done;
  logic [7:0]        rbyte;
  logic [31:0]       reg_rd;
  logic [NUM_CS-1:0] ce_next;

  assign idx       = 3'(bus_addr[ADDR_W-1:2]);
  assign acc       = bus_req && !bus_ack && !rd_wait;
  assign is_data   = (idx == IDX_DATA);
  assign launch_ok = mode_q[MB_WEN] || mode_q[MB_ALE] || mode_q[MB_CLE];
  assign seq_start = acc && is_data && !sq_busy && (!bus_wr || launch_ok);

  nfc_regs #(.TW(TW), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_mode  (acc && bus_wr && idx == IDX_MODE),
    .wr_time  (acc && bus_wr && idx == IDX_TIME),
    .wr_rst   (acc && bus_wr && idx == IDX_RST),
    .wbyte    (bus_wdata[7:0]),
    .mode_q   (mode_q),
    .time_q   (time_q),
    .rst_busy (rst_busy)
  );

  nfc_strobe #(.TW(TW)) u_strobe (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .is_rd (!bus_wr),
    .wbyte (bus_wdata[7:0]),
    .spw   (time_q[TW-1:0]),
    .hold  (time_q[2*TW-1:TW]),
    .din   (nand_din),
    .we_n  (nand_we_n),
    .re_n  (nand_re_n),
    .dout  (nand_dout),
    .doe   (nand_doe),
    .busy  (sq_busy),
    .done  (sq_done),
    .rbyte (rbyte)
  );

  always_comb begin
    case (idx)
      IDX_MODE: reg_rd = {24'd0, mode_q};
      IDX_STAT: reg_rd = {24'd0, rb_busy, sq_busy, 6'd0};
      IDX_TIME: reg_rd = {24'd0, time_q};
      IDX_RST:  reg_rd = {31'd0, rst_busy};
      default:  reg_rd = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign ce_next[g] = !(mode_q[MB_CE] && mode_q[MB_CSLO +: CS_W] == CS_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      rd_wait   <= 1'b0;
      rb_busy   <= 1'b0;
      nand_cle  <= 1'b0;
      nand_ale  <= 1'b0;
      nand_ce_n <= '1;
    end else begin
      bus_ack   <= 1'b0;
      rb_busy   <= !nand_rb_n;
      nand_cle  <= mode_q[MB_CLE];
      nand_ale  <= mode_q[MB_ALE];
      nand_ce_n <= ce_next;
      if (rd_wait && sq_done) begin
        bus_ack   <= 1'b1;
        bus_rdata <= {24'd0, rbyte};
        rd_wait   <= 1'b0;
      end else if (acc && !(is_data && sq_busy)) begin
        if (is_data && !bus_wr) begin
          rd_wait <= 1'b1;
        end else begin
          bus_ack   <= 1'b1;
          bus_rdata <= bus_wr ? 32'd0 : reg_rd;
        end
      end
    end
  end

  // R3: at most one device is selected
  a_r3_one_ce: assert property (@(posedge clk) disable iff (rst)
    $countones(~nand_ce_n) <= 1);

  // R9: acknowledge lasts one clock
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R8: busy flag follows the ready/busy pin one clock later
  a_r8_busy_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rb_busy == !$past(nand_rb_n)));

  // R9: a pending read is answered only after the strobe engine finishes
  a_r9_read_after_done: assert property (@(posedge clk) disable iff (rst)
    (rd_wait && bus_ack) |-> 1'b0);
endmodule

// File: tb/tb_nand_bus_ctrl.sv
module tb_nand_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [3:0]  nand_ce_n;
  logic [7:0]  nand_dout;
  logic [7:0]  nand_din = 8'h00;
  logic        nand_rb_n = 1'b1;

  always #10 clk = ~clk;

  nand_bus_ctrl dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
    .nand_doe(nand_doe), .nand_din(nand_din), .nand_rb_n(nand_rb_n));

  localparam logic [4:0] A_DATA = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                         A_TIME = 5'h14, A_RST = 5'h18;

  int errors = 0, checks = 0;
  bit finished = 0;

  typedef struct { bit chk; logic [31:0] exp; string tag; } exp_t;
  exp_t        sb[$];
  logic [31:0] last_rd;
  int          we_w[$], doe_w[$], re_w[$];
  logic [7:0]  we_b[$];
  int          wcnt = 0, dcnt = 0, rcnt = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: pushes the expectation, then runs the handshake
  task automatic xfer(input bit wr, input logic [4:0] a, input logic [31:0] d,
                      input bit chk, input logic [31:0] exp, input string tag);
    sb.push_back('{chk, exp, tag});
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 1'b0, '0, "wr");
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, '0, 1'b1, exp, tag);
  endtask

  // monitor: compares each acknowledged access against the queue
  always @(negedge clk) begin
    if (!rst && bus_ack) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard-underflow", bus_rdata, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        last_rd = bus_rdata;
        if (e.chk) check(bus_rdata == e.exp, e.tag, bus_rdata, e.exp);
      end
    end
  end

  // monitor: strobe and drive-window lengths
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) begin
        if (wcnt == 0) we_b.push_back(nand_dout);
        wcnt++;
      end else if (wcnt > 0) begin
        we_w.push_back(wcnt); wcnt = 0;
      end
      if (nand_doe) dcnt++;
      else if (dcnt > 0) begin doe_w.push_back(dcnt); dcnt = 0; end
      if (!nand_re_n) rcnt++;
      else if (rcnt > 0) begin re_w.push_back(rcnt); rcnt = 0; end
    end
  end

  task automatic expect_we(input int w, input logic [7:0] b, input int dw, input string tag);
    int aw, ad; logic [7:0] ab;
    aw = (we_w.size() > 0) ? we_w.pop_front() : -1;
    ab = (we_b.size() > 0) ? we_b.pop_front() : 8'hxx;
    ad = (doe_w.size() > 0) ? doe_w.pop_front() : -1;
    check(aw == w, {tag, " we width"}, aw, w);
    check(ab === b, {tag, " byte"}, ab, b);
    check(ad == dw, {tag, " drive window"}, ad, dw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(nand_ce_n == 4'hF, "R1 ce_n", nand_ce_n, 4'hF);
    check(nand_we_n && nand_re_n, "R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
    rd(A_MODE, 32'h00, "R1 mode");
    rd(A_TIME, 32'hFF, "R1 timing");
    rd(A_STAT, 32'h00, "R1 status");
    // R11 unused offsets
    rd(5'h0C, 0, "R11 0x0C");
    rd(5'h10, 0, "R11 0x10");
    rd(5'h1C, 0, "R11 0x1C");
    // R4 timing fields
    wr(A_TIME, 32'h00);
    rd(A_TIME, 32'h11, "R4 zero fields");
    wr(A_TIME, 32'h5A);
    rd(A_TIME, 32'h5A, "R4 readback");
    // R2 latch lines
    wr(A_MODE, 32'h03);
    rd(A_MODE, 32'h03, "R2 mode readback");
    repeat (2) @(negedge clk);
    check(nand_cle && nand_ale, "R2 cle/ale high", {nand_cle, nand_ale}, 2'b11);
    wr(A_MODE, 32'h01);
    repeat (2) @(negedge clk);
    check(nand_cle && !nand_ale, "R2 cle only", {nand_cle, nand_ale}, 2'b10);
    // R3 chip enables
    wr(A_MODE, 32'h18);
    repeat (2) @(negedge clk);
    check(nand_ce_n == 4'b1011, "R3 device 2", nand_ce_n, 4'b1011);
    wr(A_MODE, 32'h10);
    repeat (2) @(negedge clk);
    check(nand_ce_n == 4'b1110, "R3 device 0", nand_ce_n, 4'b1110);
    wr(A_MODE, 32'h0C);
    repeat (2) @(negedge clk);
    check(nand_ce_n == 4'b1111, "R3 disabled", nand_ce_n, 4'b1111);
    // R5 write cycle, R8 in-progress flag
    wr(A_TIME, 32'h21);
    wr(A_MODE, 32'h90);
    wr(A_DATA, 32'h1C3);
    rd(A_STAT, 32'h40, "R8 cycle flag");
    repeat (12) @(negedge clk);
    expect_we(2, 8'hC3, 6, "R5 data write");
    // R5 command cycle through CLE
    wr(A_MODE, 32'h11);
    wr(A_DATA, 32'h70);
    repeat (12) @(negedge clk);
    expect_we(2, 8'h70, 6, "R5 command write");
    // R6 ignored write
    wr(A_MODE, 32'h10);
    wr(A_DATA, 32'h55);
    rd(A_STAT, 32'h00, "R6 no cycle flag");
    repeat (10) @(negedge clk);
    check(we_w.size() == 0 && doe_w.size() == 0, "R6 no strobe", we_w.size(), 0);
    // R7 read cycle
    nand_din = 8'hA5;
    wr(A_TIME, 32'h32);
    rd(A_DATA, 32'h000000A5, "R7 read byte");
    repeat (4) @(negedge clk);
    check(re_w.size() == 1 && re_w[0] == 3, "R7 re width", re_w.size() ? re_w[0] : -1, 3);
    re_w.delete();
    // R8 busy pin
    nand_rb_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_STAT, 32'h80, "R8 busy set");
    nand_rb_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_STAT, 32'h00, "R8 busy clear");
    // R9 back-to-back accesses
    wr(A_TIME, 32'h21);
    wr(A_MODE, 32'h90);
    nand_din = 8'h3C;
    wr(A_DATA, 32'h11);
    wr(A_DATA, 32'h22);
    rd(A_DATA, 32'h3C, "R9 stalled read");
    repeat (4) @(negedge clk);
    expect_we(2, 8'h11, 6, "R9 first");
    expect_we(2, 8'h22, 6, "R9 second");
    check(re_w.size() == 1, "R9 read strobe count", re_w.size(), 1);
    re_w.delete();
    doe_w.delete();
    // R10 soft reset
    wr(A_MODE, 32'h13);
    wr(A_TIME, 32'h44);
    wr(A_RST, 32'h1);
    rd(A_RST, 32'h1, "R10 bit set");
    for (int i = 0; i < 40; i++) begin
      xfer(1'b0, A_RST, '0, 1'b0, '0, "poll");
      if (last_rd[0] == 1'b0) break;
    end
    check(last_rd[0] == 1'b0, "R10 self clear", last_rd, 0);
    rd(A_MODE, 32'h00, "R10 mode cleared");
    rd(A_TIME, 32'hFF, "R10 timing default");
    check(!nand_cle && !nand_ale, "R10 latch lines low", {nand_cle, nand_ale}, 0);
    // R5 with default timing
    wr(A_MODE, 32'h80);
    wr(A_DATA, 32'hE7);
    repeat (40) @(negedge clk);
    expect_we(16, 8'hE7, 33, "R5 default timing");
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule